// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Word Reader

This block fetches a run of 16-bit words from a three-wire serial EEPROM. The EEPROM has a chip select, a serial clock, a serial input into the device and a serial output from the device. The host pulses `start` with an even byte start address and an even, nonzero byte count. The block halves the address to get a word address. For each word it runs one complete transaction: select the device, send a command, send an address, clock in the data, then deselect. It hands the result back as a stream of bytes.

Each word opens with a select preamble. Chip select rises while the clock is low, one dummy clock pulse follows with the data line low, and then the clock returns low. Next come a start bit, a two-bit read opcode and six address bits. Each of these bits takes three pin phases. After that come sixteen data bits, and each data bit takes a high phase and a low phase. Every pin phase lasts `PHASE_CYC` clock cycles, so the serial timing can be set to meet the device's minimum phase time. A request whose last word would lie beyond the six-bit word space is refused. A request that breaks the even/nonzero rules is also refused, and no pin activity takes place for a refused request.

Top module: `serial_rom_reader`

## Requirements
- R1: After reset, `rom_cs`, `rom_sk`, `rom_di`, `busy`, `done`, `err` and `out_valid` are all low.
- R2: A `start` with an odd byte address, an odd byte count or a zero byte count pulses `err` high for one cycle, in the cycle after `start`. `busy` stays low and `rom_cs` never rises.
- R3: A request is refused through `err`, as in R2, when (byte address / 2) + (byte count / 2) exceeds 64. A request that ends exactly on word 63 is accepted.
- R4: Each word's transaction opens with `rom_cs` rising while `rom_sk` is low. Exactly one `rom_sk` pulse with `rom_di` low follows before the start bit.
- R5: The command is the bit sequence 1, 1, 0 (start bit, then read opcode), followed by the six-bit word address, all most significant bit first. `rom_di` changes only while `rom_sk` is low and holds steady throughout every `rom_sk` high phase.
- R6: Sixteen data bits are taken from `rom_do` most significant bit first. Each bit is sampled at the end of a `rom_sk` high phase.
- R7: One transaction is made per word, and `rom_cs` falls after each one. Consecutive words use consecutive word addresses. `rom_cs` is high only while `busy` is high.
- R8: Each word is delivered on `out_byte` as two bytes in consecutive cycles, each marked by a one-cycle `out_valid`: bits 7:0 first, then bits 15:8.
- R9: `done` pulses for one cycle, in the cycle after the last byte's `out_valid`. `busy` falls in that same cycle.
- R10: A `start` that arrives while `busy` is high is ignored. It changes neither the transaction in flight nor the number of `done` pulses.
- R11: Every `rom_sk` high level lasts exactly `PHASE_CYC` clock cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Request strobe, taken only while idle |
| byte_addr | input | WADDR_W+1 | Even byte start address |
| byte_cnt | input | WADDR_W+2 | Even, nonzero byte count |
| busy | output | 1 | High from acceptance until the final byte is delivered |
| done | output | 1 | One-cycle pulse when a request completes |
| err | output | 1 | One-cycle pulse when a request is refused |
| out_byte | output | 8 | Output byte |
| out_valid | output | 1 | Marks `out_byte` valid for one cycle |
| rom_cs | output | 1 | EEPROM chip select |
| rom_sk | output | 1 | EEPROM serial clock |
| rom_di | output | 1 | Serial data into the EEPROM |
| rom_do | input | 1 | Serial data from the EEPROM |

## Verification
The properties assume that `rom_do` is settled by the end of each clock-high phase. They also assume that `start` is a level the block looks at only while idle, and that the request fields are steady in the cycle `start` is high. The bench EEPROM responder changes `rom_do` a fraction of a cycle after each rising `rom_sk`, well before the sampling point. Stimulus sets the address and count together with `start` on a falling clock edge. Refused requests are checked through `err`, and the bench confirms that the responder saw no select edge at all.

// File: rtl/srd_pkg.sv
package srd_pkg;

    localparam int DATA_W = 16;
    localparam int OP_W   = 3;
    // start bit followed by the two-bit read opcode
    localparam logic [OP_W-1:0] READ_OP = 3'b110;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_SEL_OFF,
        ST_SEL_ON,
        ST_SEL_CLK,
        ST_SEL_RET,
        ST_CMD_SET,
        ST_CMD_HI,
        ST_CMD_LO,
        ST_DAT_HI,
        ST_DAT_LO,
        ST_DESEL,
        ST_EMIT_LO,
        ST_EMIT_HI
    } seq_st_e;

endpackage

// File: rtl/srd_phase_timer.sv
module srd_phase_timer #(
    parameter int PHASE_CYC = 50
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en,
    output logic tick
);
    localparam int TW = (PHASE_CYC > 1) ? $clog2(PHASE_CYC) : 1;
    localparam logic [TW-1:0] LAST = TW'(PHASE_CYC - 1);

    logic [TW-1:0] cnt_d, cnt_q;

    assign tick = en && (cnt_q == LAST);

    always_comb begin
        cnt_d = cnt_q;
        if (!en || tick)
            cnt_d = '0;
        else
            cnt_d = cnt_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else
            cnt_q <= cnt_d;
    end
endmodule

// File: rtl/srd_req_check.sv
module srd_req_check #(
    parameter int WADDR_W = 6
) (
    input  logic [WADDR_W:0]   byte_addr,
    input  logic [WADDR_W+1:0] byte_cnt,
    output logic               ok,
    output logic [WADDR_W-1:0] word_addr,
    output logic [WADDR_W:0]   word_cnt
);
    localparam int SW = WADDR_W + 2;
    localparam logic [SW-1:0] SPACE = SW'(2 ** WADDR_W);

    logic [SW-1:0] end_word;

    assign word_addr = byte_addr[WADDR_W:1];
    assign word_cnt  = byte_cnt[WADDR_W+1:1];
    assign end_word  = {2'b00, word_addr} + {1'b0, word_cnt};

    always_comb begin
        ok = 1'b1;
        if (byte_addr[0] || byte_cnt[0])
            ok = 1'b0;
        if (byte_cnt == '0)
            ok = 1'b0;
        if (end_word > SPACE)
            ok = 1'b0;
    end
endmodule

// File: rtl/srd_seq.sv
module srd_seq
    import srd_pkg::*;
#(
    parameter int WADDR_W = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               req_ok,
    input  logic [WADDR_W-1:0] req_waddr,
    input  logic [WADDR_W:0]   req_wcnt,
    input  logic               tick,
    input  logic               rom_do,
    output logic               timer_en,
    output logic               rom_cs,
    output logic               rom_sk,
    output logic               rom_di,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [7:0]         out_byte,
    output logic               out_valid
);
    localparam int TX_W = OP_W + WADDR_W;
    localparam int BW   = $clog2(DATA_W);

    typedef struct packed {
        seq_st_e             state;
        logic [WADDR_W-1:0]  waddr;
        logic [WADDR_W:0]    left;
        logic [BW-1:0]       bitn;
        logic [TX_W-1:0]     tx;
        logic [DATA_W-1:0]   rx;
        logic                cs;
        logic                sk;
        logic                di;
        logic                busy;
        logic                done;
        logic                err;
        logic                ovalid;
        logic [7:0]          obyte;
    } seq_t;

    seq_t cur_q, nxt_d;

    assign timer_en  = !(cur_q.state inside {ST_IDLE, ST_EMIT_LO, ST_EMIT_HI});
    assign rom_cs    = cur_q.cs;
    assign rom_sk    = cur_q.sk;
    assign rom_di    = cur_q.di;
    assign busy      = cur_q.busy;
    assign done      = cur_q.done;
    assign err       = cur_q.err;
    assign out_byte  = cur_q.obyte;
    assign out_valid = cur_q.ovalid;

    always_comb begin
        nxt_d        = cur_q;
        nxt_d.done   = 1'b0;
        nxt_d.err    = 1'b0;
        nxt_d.ovalid = 1'b0;

        case (cur_q.state)
            ST_IDLE: begin
                if (start) begin
                    if (req_ok) begin
                        nxt_d.state = ST_SEL_OFF;
                        nxt_d.waddr = req_waddr;
                        nxt_d.left  = req_wcnt;
                        nxt_d.busy  = 1'b1;
                    end else begin
                        nxt_d.err = 1'b1;
                    end
                end
            end
            ST_SEL_OFF: if (tick) nxt_d.state = ST_SEL_ON;
            ST_SEL_ON:  if (tick) nxt_d.state = ST_SEL_CLK;
            ST_SEL_CLK: if (tick) nxt_d.state = ST_SEL_RET;
            ST_SEL_RET: begin
                if (tick) begin
                    nxt_d.state = ST_CMD_SET;
                    nxt_d.tx    = {READ_OP, cur_q.waddr};
                    nxt_d.bitn  = '0;
                end
            end
            ST_CMD_SET: if (tick) nxt_d.state = ST_CMD_HI;
            ST_CMD_HI:  if (tick) nxt_d.state = ST_CMD_LO;
            ST_CMD_LO: begin
                if (tick) begin
                    if (cur_q.bitn == BW'(TX_W - 1)) begin
                        nxt_d.state = ST_DAT_HI;
                        nxt_d.bitn  = '0;
                    end else begin
                        nxt_d.state = ST_CMD_SET;
                        nxt_d.bitn  = cur_q.bitn + 1'b1;
                        nxt_d.tx    = {cur_q.tx[TX_W-2:0], 1'b0};
                    end
                end
            end
            ST_DAT_HI: begin
                if (tick) begin
                    nxt_d.state = ST_DAT_LO;
                    nxt_d.rx    = {cur_q.rx[DATA_W-2:0], rom_do};
                end
            end
            ST_DAT_LO: begin
                if (tick) begin
                    if (cur_q.bitn == BW'(DATA_W - 1)) begin
                        nxt_d.state = ST_DESEL;
                    end else begin
                        nxt_d.state = ST_DAT_HI;
                        nxt_d.bitn  = cur_q.bitn + 1'b1;
                    end
                end
            end
            ST_DESEL: begin
                if (tick) begin
                    nxt_d.state  = ST_EMIT_LO;
                    nxt_d.ovalid = 1'b1;
                    nxt_d.obyte  = cur_q.rx[7:0];
                end
            end
            ST_EMIT_LO: begin
                nxt_d.state  = ST_EMIT_HI;
                nxt_d.ovalid = 1'b1;
                nxt_d.obyte  = cur_q.rx[15:8];
            end
            ST_EMIT_HI: begin
                nxt_d.waddr = cur_q.waddr + 1'b1;
                nxt_d.left  = cur_q.left - 1'b1;
                if (cur_q.left == (WADDR_W+1)'(1)) begin
                    nxt_d.state = ST_IDLE;
                    nxt_d.busy  = 1'b0;
                    nxt_d.done  = 1'b1;
                end else begin
                    nxt_d.state = ST_SEL_OFF;
                end
            end
            default: nxt_d.state = ST_IDLE;
        endcase

        // pin levels follow the state being entered, so they are registered
        nxt_d.cs = nxt_d.state inside {ST_SEL_ON, ST_SEL_CLK, ST_SEL_RET,
                                       ST_CMD_SET, ST_CMD_HI, ST_CMD_LO,
                                       ST_DAT_HI, ST_DAT_LO};
        nxt_d.sk = nxt_d.state inside {ST_SEL_CLK, ST_CMD_HI, ST_DAT_HI};
        nxt_d.di = (nxt_d.state inside {ST_CMD_SET, ST_CMD_HI, ST_CMD_LO})
                   ? nxt_d.tx[TX_W-1] : 1'b0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_q       <= '0;
            cur_q.state <= ST_IDLE;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/serial_rom_reader.sv
module serial_rom_reader #(
    parameter int WADDR_W   = 6,
    parameter int PHASE_CYC = 50
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [WADDR_W:0]   byte_addr,
    input  logic [WADDR_W+1:0] byte_cnt,
    output logic               busy,
    output logic               done,
    output logic               err,
    output logic [7:0]         out_byte,
    output logic               out_valid,
    output logic               rom_cs,
    output logic               rom_sk,
    output logic               rom_di,
    input  logic               rom_do
);
    logic               req_ok;
    logic [WADDR_W-1:0] req_waddr;
    logic [WADDR_W:0]   req_wcnt;
    logic               timer_en;
    logic               tick;

    srd_req_check #(.WADDR_W(WADDR_W)) u_check (
        .byte_addr (byte_addr),
        .byte_cnt  (byte_cnt),
        .ok        (req_ok),
        .word_addr (req_waddr),
        .word_cnt  (req_wcnt)
    );

    srd_phase_timer #(.PHASE_CYC(PHASE_CYC)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (timer_en),
        .tick  (tick)
    );

    srd_seq #(.WADDR_W(WADDR_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start),
        .req_ok    (req_ok),
        .req_waddr (req_waddr),
        .req_wcnt  (req_wcnt),
        .tick      (tick),
        .rom_do    (rom_do),
        .timer_en  (timer_en),
        .rom_cs    (rom_cs),
        .rom_sk    (rom_sk),
        .rom_di    (rom_di),
        .busy      (busy),
        .done      (done),
        .err       (err),
        .out_byte  (out_byte),
        .out_valid (out_valid)
    );
endmodule

// File: rtl/serial_rom_reader_chk.sv
module serial_rom_reader_chk #(
    parameter int PHASE_CYC = 50
) (
    input logic clk,
    input logic rst_n,
    input logic rom_cs,
    input logic rom_sk,
    input logic rom_di,
    input logic busy,
    input logic done,
    input logic err,
    input logic out_valid
);
    logic [15:0] hi_len_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_len_q <= '0;
        else if (rom_sk)
            hi_len_q <= hi_len_q + 1'b1;
        else
            hi_len_q <= '0;
    end

    // R11
    sk_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_sk) |-> (hi_len_q == 16'(PHASE_CYC)));

    // R5
    di_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rom_sk && $past(rom_sk)) |-> $stable(rom_di));

    // R4
    sel_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rom_cs) |-> !rom_sk);

    // R7
    cs_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rom_cs |-> busy);

    // R8
    byte_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_valid) |=> out_valid);

    // R8
    byte_max_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |=> !out_valid);

    // R9
    done_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> done);

    // R9
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    err_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (!busy && !rom_cs));
endmodule

bind serial_rom_reader serial_rom_reader_chk #(.PHASE_CYC(PHASE_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_cs    (rom_cs),
    .rom_sk    (rom_sk),
    .rom_di    (rom_di),
    .busy      (busy),
    .done      (done),
    .err       (err),
    .out_valid (out_valid)
);

// File: tb/serial_rom_reader_bench.sv
`timescale 1ns/1ps
module serial_rom_reader_bench;
    localparam int P  = 4;
    localparam int AW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start = 1'b0;
    logic [AW:0]   byte_addr = '0;
    logic [AW+1:0] byte_cnt = '0;
    logic busy, done, err, out_valid, rom_cs, rom_sk, rom_di;
    logic [7:0] out_byte;
    logic rom_do = 1'b0;

    always #10 clk = ~clk;

    serial_rom_reader #(.WADDR_W(AW), .PHASE_CYC(P)) u_serial_rom_reader (
        .clk(clk), .rst_n(rst_n), .start(start),
        .byte_addr(byte_addr), .byte_cnt(byte_cnt),
        .busy(busy), .done(done), .err(err),
        .out_byte(out_byte), .out_valid(out_valid),
        .rom_cs(rom_cs), .rom_sk(rom_sk), .rom_di(rom_di), .rom_do(rom_do)
    );

    int n_tests = 0;
    int n_fail  = 0;

    function automatic logic [15:0] rom_word(input logic [5:0] a);
        logic [7:0] x;
        x = {2'b00, a};
        return {x * 8'd7 + 8'h31, x ^ 8'h9C};
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // behavioural EEPROM responder
    int m_pre = 0, m_cmdn = 0, m_dbit = 0, m_txn = 0, m_proto = 0;
    bit m_started = 0;
    logic [8:0] m_cmd = '0;
    logic [5:0] m_addr = '0;

    always @(posedge rom_cs) begin
        m_started = 0; m_pre = 0; m_cmdn = 0; m_dbit = 0; m_cmd = '0;
        if (rom_sk) m_proto++;
    end

    always @(negedge rom_cs) begin
        if (rst_n) begin
            if (m_pre != 1 || m_cmdn != 9 || m_dbit != 16) m_proto++;
            m_txn++;
        end
    end

    always @(posedge rom_sk) begin
        if (rom_cs === 1'b1) begin
            if (!m_started) begin
                if (rom_di) begin
                    m_started = 1; m_cmd = 9'd1; m_cmdn = 1;
                end else begin
                    m_pre++;
                end
            end else if (m_cmdn < 9) begin
                m_cmd = {m_cmd[7:0], rom_di};
                m_cmdn++;
                if (m_cmdn == 9) begin
                    if (m_cmd[8:6] != 3'b110) m_proto++;
                    m_addr = m_cmd[5:0];
                end
            end else begin
                logic [15:0] w;
                w = rom_word(m_addr);
                #1 rom_do = w[15 - m_dbit];
                m_dbit++;
            end
        end
    end

    // output monitor
    logic [7:0] got [128];
    int ng = 0, done_cnt = 0, seq_bad = 0, sk_bad = 0, hl = 0;
    bit seen_done = 0, seen_err = 0, busy_seen = 0, prev_valid = 0, prev_done = 0;

    always @(negedge clk) begin
        if (out_valid) begin
            if (ng < 128) got[ng] = out_byte;
            ng++;
        end
        if (done) begin
            seen_done = 1; done_cnt++;
            if (!prev_valid || prev_done || busy) seq_bad++;
        end
        if (err) seen_err = 1;
        if (busy) busy_seen = 1;
        prev_valid = out_valid;
        prev_done  = done;
        if (rom_sk) hl++;
        else if (hl != 0) begin
            if (hl != P) sk_bad++;
            hl = 0;
        end
    end

    task automatic clear_flags();
        ng = 0; m_txn = 0; m_proto = 0; done_cnt = 0; seq_bad = 0;
        seen_done = 0; seen_err = 0; busy_seen = 0;
    endtask

    task automatic pulse_start(input logic [7:0] a, input logic [7:0] c);
        @(negedge clk);
        byte_addr = a[AW:0]; byte_cnt = c; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_end();
        for (int k = 0; k < 40000 && !seen_done && !seen_err; k++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic check_bytes(input logic [7:0] a, input logic [7:0] c);
        int bad = 0;
        for (int i = 0; i < c; i++) begin
            logic [15:0] w;
            logic [7:0] e;
            w = rom_word(6'((a >> 1) + (i >> 1)));
            e = (i % 2 == 1) ? w[15:8] : w[7:0];
            if (got[i] !== e) bad++;
        end
        // R6 R8: MSB-first data, low byte first
        chk(bad == 0 && ng == c, "R6 R8 bytes", ng - bad, c);
        // R7: one transaction per word
        chk(m_txn == c / 2, "R7 transactions", m_txn, c / 2);
        // R4 R5: select preamble and command framing
        chk(m_proto == 0, "R4 R5 framing", m_proto, 0);
        // R9: single done after last byte
        chk(seen_done && done_cnt == 1 && seq_bad == 0, "R9 done", done_cnt, 1);
    endtask

    task automatic run_req(input logic [7:0] a, input logic [7:0] c, input bit e);
        clear_flags();
        pulse_start(a, c);
        wait_end();
        if (e) begin
            // R2 R3: refusal, no pin activity
            chk(seen_err && !busy_seen, "R2 R3 refused", int'(seen_err), 1);
            chk(ng == 0 && m_txn == 0 && !seen_done, "R2 R3 no traffic", m_txn, 0);
        end else begin
            chk(!seen_err, "R3 accepted", int'(seen_err), 0);
            check_bytes(a, c);
        end
    endtask

    // {byte address, byte count, expect refusal}
    localparam int NV = 10;
    localparam logic [16:0] VECS [NV] = '{
        {8'd0,   8'd2,   1'b0},
        {8'd10,  8'd6,   1'b0},
        {8'd126, 8'd2,   1'b0},
        {8'd124, 8'd4,   1'b0},
        {8'd3,   8'd2,   1'b1},
        {8'd4,   8'd3,   1'b1},
        {8'd8,   8'd0,   1'b1},
        {8'd126, 8'd4,   1'b1},
        {8'd0,   8'd130, 1'b1},
        {8'd0,   8'd128, 1'b0}
    };

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        chk({rom_cs, rom_sk, rom_di, busy, done, err, out_valid} == 7'b0,
            "R1 reset", int'({rom_cs, rom_sk, rom_di, busy, done, err, out_valid}), 0);

        for (int v = 0; v < NV; v++)
            run_req(VECS[v][16:9], VECS[v][8:1], VECS[v][0]);

        // R10: start while busy is ignored
        clear_flags();
        pulse_start(8'd20, 8'd4);
        repeat (30) @(negedge clk);
        chk(busy == 1'b1, "R10 busy", int'(busy), 1);
        pulse_start(8'd40, 8'd2);
        wait_end();
        chk(!seen_err, "R10 no err", int'(seen_err), 0);
        check_bytes(8'd20, 8'd4);
        repeat (20) @(negedge clk);
        chk(done_cnt == 1 && !busy, "R10 single done", done_cnt, 1);

        // R11: clock high phase length
        chk(sk_bad == 0, "R11 phase length", sk_bad, 0);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule